// File: doc/BRIEF.md
# Load/Store Size and Extension Unit

This block sits between a 64-bit register file and a memory port that is one doubleword wide. On the load side it receives the doubleword the memory returns, the low three bits of the access address and the access code. It pulls out the addressed byte, halfword, word or doubleword, widens it to 64 bits with either sign or zero fill, and presents the result in a register one cycle after the memory data arrives.

On the store side it forms the effective address from a base register and a signed 12-bit displacement. It copies the low bits of the source register into every lane group of the doubleword, so the addressed lanes carry the data, and produces an 8-bit byte-enable mask that covers exactly the lanes being written. An access whose address is not a multiple of its size is flagged on either side: no lanes are enabled, or the load result is zero.

Top module: `ls_size_ext_unit`

## Requirements
- R1: `st_addr` equals `st_base` plus `st_offset` sign-extended from 12 bits, with 64-bit wraparound.
- R2: Load codes 000 (byte), 001 (half) and 010 (word) take the item whose lowest byte is lane `rsp_addr_lo` (lane n is `rsp_rdata[8n+7:8n]`, little-endian) and sign-extend it to 64 bits.
- R3: Load codes 100 (byte), 101 (half) and 110 (word) take the same item and zero-extend it to 64 bits.
- R4: Load codes 011 and 111 return all of `rsp_rdata` unchanged when `rsp_addr_lo` is 0.
- R5: A load whose `rsp_addr_lo` is not a multiple of its size (1, 2, 4 or 8 bytes, from code bits [1:0]) gives `ld_misaligned` = 1 and `ld_data` = 0; an aligned load gives `ld_misaligned` = 0.
- R6: `ld_valid` is `rsp_valid` delayed by exactly one clock; while `rsp_valid` is 0, `ld_data` and `ld_misaligned` keep their values.
- R7: `st_wdata` holds the low 8, 16 or 32 bits of `st_src` repeated 8, 4 or 2 times for store codes x00, x01 and x10, and all of `st_src` for x11.
- R8: For an aligned store of size S bytes at low address bits L (`st_addr[2:0]`), `st_be` has ones in bits L to L+S-1 and zeros elsewhere, and `st_misaligned` is 0.
- R9: A store whose low address bits are not a multiple of its size gives `st_misaligned` = 1 and `st_be` = 0.
- R10: Bit 2 of `st_funct3` has no effect on `st_wdata`, `st_be` or `st_misaligned`.
- R11: While `rst` is high at a clock edge, `ld_valid`, `ld_data` and `ld_misaligned` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_base | input | 64 | Base register value for the store address |
| st_offset | input | 12 | Signed store displacement |
| st_funct3 | input | 3 | Store size code |
| st_src | input | 64 | Source register value to be stored |
| st_addr | output | 64 | Effective store address |
| st_wdata | output | 64 | Lane-replicated write data |
| st_be | output | 8 | Byte-lane write enables |
| st_misaligned | output | 1 | Store address not aligned to its size |
| rsp_valid | input | 1 | Memory read data present this cycle |
| rsp_rdata | input | 64 | Doubleword returned by memory |
| rsp_addr_lo | input | 3 | Low address bits of the load |
| rsp_funct3 | input | 3 | Load size and extension code |
| ld_valid | output | 1 | Registered load result valid |
| ld_data | output | 64 | Registered, extended load result |
| ld_misaligned | output | 1 | Registered load misalignment flag |

## Verification
The store side holds no state, so a fault in its lane decode or replication appears at `st_be` and `st_wdata` in the same cycle the inputs change, and random sizes at all eight lane offsets reach every enable bit. On the load side the only state is the result register: a wrong extension or lane pick shows on `ld_data` one edge after `rsp_valid`, and a hold fault shows on the first idle cycle that follows, so idle gaps are mixed into the stream. Directed cases place a set top bit at the highest lane for each size, where a sign-fill error or a lane-shift error is easiest to see.

// File: rtl/lsu_size_pkg.sv
package lsu_size_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      zext;
    } acc_kind_t;

    function automatic acc_kind_t decode_kind(input logic [2:0] code);
        acc_kind_t k;
        k.size = acc_size_e'(code[1:0]);
        k.zext = code[2];
        return k;
    endfunction

    function automatic logic [2:0] align_mask(input acc_size_e sz);
        logic [3:0] span;
        span = 4'd1 << sz;
        return 3'(span - 4'd1);
    endfunction

    function automatic logic off_align(input acc_size_e sz, input logic [2:0] lo);
        return (lo & align_mask(sz)) != 3'd0;
    endfunction

endpackage

// File: rtl/lsu_agu.sv
module lsu_agu #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] disp,
    output logic [XLEN-1:0]  addr
);
    localparam int FILL_W = XLEN - IMM_W;

    logic [XLEN-1:0] disp_ext;

    always_comb begin
        disp_ext = {{FILL_W{disp[IMM_W-1]}}, disp};
        addr     = base + disp_ext;
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_size_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rdata,
    input  logic [2:0]      lo,
    input  logic [2:0]      code,
    output logic [XLEN-1:0] result,
    output logic            misaligned
);
    acc_kind_t       kind;
    logic [XLEN-1:0] shifted;
    logic            fill;

    always_comb begin
        kind       = decode_kind(code);
        misaligned = off_align(kind.size, lo);
        shifted    = rdata >> {lo, 3'b000};
        fill       = 1'b0;
        result     = '0;
        unique case (kind.size)
            SZ_BYTE: begin
                fill   = ~kind.zext & shifted[7];
                result = {{(XLEN-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill   = ~kind.zext & shifted[15];
                result = {{(XLEN-16){fill}}, shifted[15:0]};
            end
            SZ_WORD: begin
                fill   = ~kind.zext & shifted[31];
                result = {{(XLEN-32){fill}}, shifted[31:0]};
            end
            default: result = shifted;
        endcase
        if (misaligned) result = '0;
    end
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
    import lsu_size_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   src,
    input  logic [2:0]        lo,
    input  logic [2:0]        code,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN/8-1:0] be,
    output logic              misaligned
);
    localparam int LANES = XLEN / 8;

    acc_kind_t  kind;
    logic [3:0] span;
    logic [3:0] first;
    logic [3:0] last_excl;

    always_comb begin
        kind       = decode_kind({1'b0, code[1:0]});
        misaligned = off_align(kind.size, lo);
        span       = 4'd1 << kind.size;
        first      = {1'b0, lo};
        last_excl  = first + span;
        unique case (kind.size)
            SZ_BYTE: wdata = {(XLEN/8){src[7:0]}};
            SZ_HALF: wdata = {(XLEN/16){src[15:0]}};
            SZ_WORD: wdata = {(XLEN/32){src[31:0]}};
            default: wdata = src;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            be[g] = ~misaligned && (4'(g) >= first) && (4'(g) < last_excl);
        end
    end
endmodule

// File: rtl/ls_size_ext_unit.sv
module ls_size_ext_unit
    import lsu_size_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   st_base,
    input  logic [IMM_W-1:0]  st_offset,
    input  logic [2:0]        st_funct3,
    input  logic [XLEN-1:0]   st_src,
    output logic [XLEN-1:0]   st_addr,
    output logic [XLEN-1:0]   st_wdata,
    output logic [XLEN/8-1:0] st_be,
    output logic              st_misaligned,
    input  logic              rsp_valid,
    input  logic [XLEN-1:0]   rsp_rdata,
    input  logic [2:0]        rsp_addr_lo,
    input  logic [2:0]        rsp_funct3,
    output logic              ld_valid,
    output logic [XLEN-1:0]   ld_data,
    output logic              ld_misaligned
);
    logic [XLEN-1:0] ld_next;
    logic            ld_mis_next;

    lsu_agu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agu (
        .base (st_base),
        .disp (st_offset),
        .addr (st_addr)
    );

    lsu_store_align #(.XLEN(XLEN)) u_st (
        .src        (st_src),
        .lo         (st_addr[2:0]),
        .code       (st_funct3),
        .wdata      (st_wdata),
        .be         (st_be),
        .misaligned (st_misaligned)
    );

    lsu_load_align #(.XLEN(XLEN)) u_ld (
        .rdata      (rsp_rdata),
        .lo         (rsp_addr_lo),
        .code       (rsp_funct3),
        .result     (ld_next),
        .misaligned (ld_mis_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid      <= 1'b0;
            ld_data       <= '0;
            ld_misaligned <= 1'b0;
        end else begin
            ld_valid <= rsp_valid;
            if (rsp_valid) begin
                ld_data       <= ld_next;
                ld_misaligned <= ld_mis_next;
            end
        end
    end

    AST_ST_MIS_NO_BE: assert property (@(posedge clk) disable iff (rst)
        st_misaligned |-> st_be == '0);  // R9
    AST_ST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !st_misaligned |-> $countones(st_be) == (1 << st_funct3[1:0]));  // R8
    AST_LD_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> ld_valid);  // R6
    AST_LD_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> !ld_valid);  // R6
    AST_LD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> $stable(ld_data) && $stable(ld_misaligned));  // R6
    AST_LD_MIS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ld_misaligned |-> ld_data == '0);  // R5
    AST_LD_SEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_funct3 == 3'b000)
        |=> (ld_data[XLEN-1:8] == '0) || (ld_data[XLEN-1:7] == '1));  // R2
    AST_LD_ZEXT_WORD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_funct3 == 3'b110) |=> ld_data[XLEN-1:32] == '0);  // R3
endmodule

// File: tb/ls_size_ext_unit_tb.sv
module ls_size_ext_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] st_base, st_src, st_addr, st_wdata;
    logic [11:0] st_offset;
    logic [2:0]  st_funct3;
    logic [7:0]  st_be;
    logic        st_misaligned;
    logic        rsp_valid;
    logic [63:0] rsp_rdata, ld_data;
    logic [2:0]  rsp_addr_lo, rsp_funct3;
    logic        ld_valid, ld_misaligned;

    int errors = 0;
    int checks = 0;
    logic [63:0] held_data;
    logic        held_mis;

    always #5 clk = ~clk;

    ls_size_ext_unit u_dut (
        .clk(clk), .rst(rst),
        .st_base(st_base), .st_offset(st_offset), .st_funct3(st_funct3), .st_src(st_src),
        .st_addr(st_addr), .st_wdata(st_wdata), .st_be(st_be), .st_misaligned(st_misaligned),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_addr_lo(rsp_addr_lo),
        .rsp_funct3(rsp_funct3), .ld_valid(ld_valid), .ld_data(ld_data),
        .ld_misaligned(ld_misaligned)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int size_bytes(input logic [2:0] code);
        return 1 << code[1:0];
    endfunction

    function automatic logic exp_mis(input logic [2:0] code, input logic [2:0] lo);
        return (int'(lo) % size_bytes(code)) != 0;
    endfunction

    function automatic logic [63:0] exp_load(input logic [63:0] d, input logic [2:0] lo,
                                             input logic [2:0] code);
        logic [63:0] r;
        int n;
        if (exp_mis(code, lo)) return 64'd0;
        n = size_bytes(code);
        r = 64'd0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(int'(lo)+i) +: 8];
        if (n < 8 && code[2] == 1'b0 && r[8*n-1])
            for (int i = n; i < 8; i++) r[8*i +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [63:0] exp_wdata(input logic [63:0] s, input logic [2:0] code);
        logic [63:0] r;
        int n;
        n = size_bytes(code);
        for (int i = 0; i < 8; i++) r[8*i +: 8] = s[8*(i % n) +: 8];
        return r;
    endfunction

    function automatic logic [7:0] exp_be(input logic [2:0] lo, input logic [2:0] code);
        logic [7:0] r;
        r = 8'd0;
        if (exp_mis(code, lo)) return r;
        for (int i = 0; i < size_bytes(code); i++) r[int'(lo) + i] = 1'b1;
        return r;
    endfunction

    // Drive one cycle (at negedge), check stores combinationally, then loads after the edge.
    task automatic step(input logic [63:0] base, input logic [11:0] off, input logic [2:0] sf,
                        input logic [63:0] src, input logic rv, input logic [63:0] rd,
                        input logic [2:0] lo, input logic [2:0] lf);
        logic [63:0] ea;
        st_base = base; st_offset = off; st_funct3 = sf; st_src = src;
        rsp_valid = rv; rsp_rdata = rd; rsp_addr_lo = lo; rsp_funct3 = lf;
        #1;
        ea = base + {{52{off[11]}}, off};
        chk("R1 st_addr", st_addr, ea);
        chk("R7/R10 st_wdata", st_wdata, exp_wdata(src, sf));
        chk("R8/R9/R10 st_be", {56'd0, st_be}, {56'd0, exp_be(ea[2:0], sf)});
        chk("R9/R10 st_misaligned", {63'd0, st_misaligned}, {63'd0, exp_mis(sf, ea[2:0])});
        @(posedge clk);
        @(negedge clk);
        chk("R6 ld_valid", {63'd0, ld_valid}, {63'd0, rv});
        if (rv) begin
            held_data = exp_load(rd, lo, lf);
            held_mis  = exp_mis(lf, lo);
        end
        chk("R2/R3/R4/R5 ld_data", ld_data, held_data);
        chk("R5 ld_misaligned", {63'd0, ld_misaligned}, {63'd0, held_mis});
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        st_base = '0; st_offset = '0; st_funct3 = '0; st_src = '0;
        rsp_valid = 1'b0; rsp_rdata = '0; rsp_addr_lo = '0; rsp_funct3 = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 ld_valid reset", {63'd0, ld_valid}, 64'd0);
        chk("R11 ld_data reset", ld_data, 64'd0);
        chk("R11 ld_misaligned reset", {63'd0, ld_misaligned}, 64'd0);
        rst = 1'b0;
        held_data = 64'd0;
        held_mis  = 1'b0;

        // Directed corners
        step(64'h100, 12'hFFF, 3'b000, 64'h1122334455667788, 1'b1,
             64'h80AA_0000_0000_0000, 3'd7, 3'b000);              // R1 negative offset, R2 byte lane 7
        chk("R2 byte sign fill", ld_data, 64'hFFFF_FFFF_FFFF_FF80);
        step(64'h106, 12'h000, 3'b001, 64'hABCD, 1'b1,
             64'h80AA_0000_0000_0000, 3'd7, 3'b100);               // R8 half at lane 6, R3
        chk("R3 byte zero fill", ld_data, 64'h0000_0000_0000_0080);
        step(64'h102, 12'h000, 3'b010, 64'h0, 1'b1,
             64'h8000_0000_1234_5678, 3'd4, 3'b010);               // R9 word misaligned, R2 word
        chk("R2 word sign fill", ld_data, 64'hFFFF_FFFF_8000_0000);
        step(64'h100, 12'h7FF, 3'b111, 64'hDEADBEEF_CAFEF00D, 1'b1,
             64'hDEADBEEF_CAFEF00D, 3'd0, 3'b011);                // R10 code bit2 on store, R4
        chk("R4 doubleword", ld_data, 64'hDEADBEEF_CAFEF00D);
        step(64'h0, 12'h0, 3'b011, 64'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 3'b001);
        chk("R5 misaligned half zero", ld_data, 64'd0);
        step(64'h0, 12'h0, 3'b000, 64'h1, 1'b0, 64'h1234, 3'd0, 3'b011);
        chk("R6 hold while idle", ld_data, 64'd0);
        step(64'h0, 12'h0, 3'b000, 64'h1, 1'b1, 64'h1234_5678_9ABC_DEF0, 3'd0, 3'b111);
        chk("R4 code 111", ld_data, 64'h1234_5678_9ABC_DEF0);

        // Random stream
        for (int it = 0; it < 400; it++) begin
            logic [63:0] b, s, d;
            logic [2:0]  lo, lf, sf;
            logic        rv;
            b  = {$urandom, $urandom};
            s  = {$urandom, $urandom};
            d  = {$urandom, $urandom};
            sf = 3'($urandom);
            lf = 3'($urandom);
            lo = 3'($urandom);
            if ($urandom % 2 == 0) begin
                lo = lo & ~3'((1 << lf[1:0]) - 1);
                b[2:0] = b[2:0] & ~3'((1 << sf[1:0]) - 1);
            end
            rv = ($urandom % 4) != 0;
            step(b, ($urandom % 2 == 0) ? 12'h0 : 12'($urandom), sf, s, rv, d, lo, lf);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule